// File: doc/BRIEF.md
# Register-Offset Load/Store Unit

This unit executes the group of 16-bit compressed instructions that move data between a register and memory, with the address formed from two registers. A one-cycle `start` pulse presents the instruction word. The unit decodes it and reads the base, offset and data registers through three combinational register-file read ports. It adds base and offset to form the effective address and issues exactly one sized request on a single-beat memory port.

For loads, the unit aligns the returned data, extends it and writes it back to the register file. Misaligned word loads and unsigned halfword loads do not fault. Instead, the aligned bus data is rotated right by eight bits for each byte of address offset. Signed halfword loads are never rotated.

An instruction word outside the group is refused with a one-cycle `unhandled` pulse, and no bus traffic is generated.

The controller has three states:
- `ST_IDLE` waits for `start`.
  - A group hit latches the request and moves to `ST_ACCESS`.
  - A miss moves to `ST_REJECT`.
  - A `start` pulse that arrives while the unit is not in `ST_IDLE` is ignored.
- `ST_ACCESS` holds `mem_req` and waits for `mem_ready`. In the cycle `mem_ready` is seen, the unit asserts `done`, performs any write-back and returns to `ST_IDLE`.
- `ST_REJECT` asserts `unhandled` for one cycle and returns to `ST_IDLE`.

Top module: `rol_ldst_unit`

## Requirements
- R1: An instruction is accepted only when bits [15:12] equal 0101. Any other value gives exactly one `unhandled` pulse, in the cycle after `start`, with no `done`, no `rf_we` and no memory request.
- R2: The effective address is the 32-bit sum of the base and offset register values, modulo 2^32. Bits [5:3] select the base register, bits [8:6] the offset register and bits [2:0] the data register.
- R3: `mem_size` is 0 for byte, 1 for halfword and 2 for word. Word accesses drive `mem_addr` with bits [1:0] cleared, halfword accesses with bit 0 cleared, and byte accesses with the full effective address.
- R4: With bit 9 clear, bits [11:10] select: 00 word store, 01 byte store, 10 word load, 11 zero-extended byte load.
- R5: With bit 9 set, bits [11:10] select: 00 halfword store, 01 zero-extended halfword load, 10 sign-extended byte load, 11 sign-extended halfword load.
- R6: Stores drive `mem_we`=1. `mem_wdata` carries the data register's low 8 bits (byte), low 16 bits (halfword) or all 32 bits (word), with the unused upper bits zero.
- R7: A word load writes back the 32-bit bus data rotated right by 8 × address[1:0] bits.
- R8: An unsigned halfword load takes `mem_rdata[15:0]`, zero-extends it, then rotates the result right by 8 × address[0] bits.
- R9: A signed halfword load sign-extends `mem_rdata[15:0]` with no rotation at any address. Byte loads extend `mem_rdata[7:0]` by sign (signed) or with zeros (unsigned). Bus bits above the access size are ignored.
- R10: Each accepted instruction raises `mem_req` in the cycle after `start`. The request is held with stable address, size and direction until `mem_ready`. `done` is asserted for one cycle in the cycle `mem_ready` is seen, and exactly one request is completed.
- R11: A load asserts `rf_we` for exactly one cycle, in the `done` cycle, with `rf_waddr` equal to the data register index. A store never asserts `rf_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle instruction strobe |
| instr | input | 16 | Instruction word, valid with `start` |
| done | output | 1 | One-cycle completion pulse |
| unhandled | output | 1 | One-cycle refusal pulse for a word outside the group |
| rf_base_idx | output | 3 | Read index for the base register |
| rf_off_idx | output | 3 | Read index for the offset register |
| rf_dat_idx | output | 3 | Read index for the store-data register |
| rf_base_val | input | 32 | Base register value |
| rf_off_val | input | 32 | Offset register value |
| rf_dat_val | input | 32 | Store-data register value |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_addr | output | 32 | Aligned bus address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Response strobe; read data is valid with it |
| mem_rdata | input | 32 | Read data |

## Verification
The in-RTL assertions check the cycle-level protocol on every cycle:
- the request stays stable until `mem_ready`;
- word and halfword addresses are aligned;
- `rf_we` occurs only in a `done` cycle, and never during a store;
- `done` and `unhandled` are single-cycle pulses;
- a refusal never overlaps bus activity.

The data values themselves can only be shown by the bench's scenarios. These include the rotated word and halfword results at every byte offset, the sign and zero extension, the store lane contents, address wraparound, and the effective address reaching the bus. The bench sweeps all eight operations over all four low address bits with several register values and response latencies, and offers every other top nibble.

// File: rtl/rol_pkg.sv
package rol_pkg;

    localparam int RIDX_W = 3;
    localparam logic [3:0] GROUP_CODE = 4'b0101;

    // {bit9, bits[11:10]}
    typedef enum logic [2:0] {
        OP_SW  = 3'b000,
        OP_SB  = 3'b001,
        OP_LW  = 3'b010,
        OP_LBU = 3'b011,
        OP_SH  = 3'b100,
        OP_LHU = 3'b101,
        OP_LBS = 3'b110,
        OP_LHS = 3'b111
    } rol_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } rol_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_REJECT = 2'd2
    } rol_state_e;

    function automatic logic op_is_load(input rol_op_e op);
        case (op)
            OP_SW, OP_SB, OP_SH: return 1'b0;
            default:             return 1'b1;
        endcase
    endfunction

    function automatic rol_size_e op_size(input rol_op_e op);
        case (op)
            OP_SW, OP_LW:          return SZ_WORD;
            OP_SB, OP_LBU, OP_LBS: return SZ_BYTE;
            default:               return SZ_HALF;
        endcase
    endfunction

endpackage

// File: rtl/rol_decode.sv
module rol_decode
    import rol_pkg::*;
(
    input  logic [15:0]       instr,
    output logic              hit,
    output rol_op_e           op,
    output logic [RIDX_W-1:0] off_idx,
    output logic [RIDX_W-1:0] base_idx,
    output logic [RIDX_W-1:0] dat_idx,
    output logic              is_load,
    output rol_size_e         size
);

    always_comb begin
        hit      = (instr[15:12] == GROUP_CODE);
        op       = rol_op_e'({instr[9], instr[11:10]});
        off_idx  = instr[8:6];
        base_idx = instr[5:3];
        dat_idx  = instr[2:0];
        is_load  = op_is_load(op);
        size     = op_size(op);
    end

endmodule

// File: rtl/rol_agen.sv
module rol_agen
    import rol_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] off,
    input  logic [XLEN-1:0] dat,
    input  rol_size_e       size,
    output logic [XLEN-1:0] bus_addr,
    output logic [1:0]      lo,
    output logic [XLEN-1:0] wdata
);

    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    logic [XLEN-1:0] eff;

    always_comb begin
        eff = base + off;
        lo  = eff[1:0];
        case (size)
            SZ_WORD: begin
                bus_addr = {eff[XLEN-1:2], 2'b00};
                wdata    = dat;
            end
            SZ_HALF: begin
                bus_addr = {eff[XLEN-1:1], 1'b0};
                wdata    = {{(XLEN-HALF_W){1'b0}}, dat[HALF_W-1:0]};
            end
            default: begin
                bus_addr = eff;
                wdata    = {{(XLEN-BYTE_W){1'b0}}, dat[BYTE_W-1:0]};
            end
        endcase
    end

    always_comb begin
        if (size == SZ_WORD) begin
            // R3
            word_low_zero_chk: assert (bus_addr[1:0] == 2'b00 || $isunknown(size));
        end
    end

endmodule

// File: rtl/rol_lalign.sv
module rol_lalign
    import rol_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  rol_op_e         op,
    input  logic [1:0]      lo,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] result
);

    localparam int SH_W   = $clog2(XLEN);
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    function automatic logic [XLEN-1:0] rotr(input logic [XLEN-1:0] x,
                                              input logic [SH_W-1:0] sh);
        logic [2*XLEN-1:0] d;
        d = {x, x} >> sh;
        return d[XLEN-1:0];
    endfunction

    logic [SH_W-1:0] sh_word;
    logic [SH_W-1:0] sh_half;

    always_comb begin
        sh_word = SH_W'({lo, 3'b000});
        sh_half = SH_W'({lo[0], 3'b000});
        case (op)
            OP_LW:  result = rotr(rdata, sh_word);
            OP_LHU: result = rotr({{(XLEN-HALF_W){1'b0}}, rdata[HALF_W-1:0]}, sh_half);
            OP_LHS: result = {{(XLEN-HALF_W){rdata[HALF_W-1]}}, rdata[HALF_W-1:0]};
            OP_LBU: result = {{(XLEN-BYTE_W){1'b0}}, rdata[BYTE_W-1:0]};
            OP_LBS: result = {{(XLEN-BYTE_W){rdata[BYTE_W-1]}}, rdata[BYTE_W-1:0]};
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/rol_ldst_unit.sv
module rol_ldst_unit
    import rol_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    output logic              done,
    output logic              unhandled,
    output logic [RIDX_W-1:0] rf_base_idx,
    output logic [RIDX_W-1:0] rf_off_idx,
    output logic [RIDX_W-1:0] rf_dat_idx,
    input  logic [XLEN-1:0]   rf_base_val,
    input  logic [XLEN-1:0]   rf_off_val,
    input  logic [XLEN-1:0]   rf_dat_val,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_ready,
    input  logic [XLEN-1:0]   mem_rdata
);

    rol_state_e state_q, state_d;

    logic              dec_hit;
    rol_op_e           dec_op;
    logic              dec_load;
    rol_size_e         dec_size;
    logic [XLEN-1:0]   gen_addr;
    logic [1:0]        gen_lo;
    logic [XLEN-1:0]   gen_wdata;

    rol_op_e           op_q;
    logic              load_q;
    rol_size_e         size_q;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   wdata_q;
    logic [1:0]        lo_q;
    logic [RIDX_W-1:0] rd_q;
    logic [XLEN-1:0]   aligned;

    rol_decode u_decode (
        .instr    (instr),
        .hit      (dec_hit),
        .op       (dec_op),
        .off_idx  (rf_off_idx),
        .base_idx (rf_base_idx),
        .dat_idx  (rf_dat_idx),
        .is_load  (dec_load),
        .size     (dec_size)
    );

    rol_agen #(.XLEN(XLEN)) u_agen (
        .base     (rf_base_val),
        .off      (rf_off_val),
        .dat      (rf_dat_val),
        .size     (dec_size),
        .bus_addr (gen_addr),
        .lo       (gen_lo),
        .wdata    (gen_wdata)
    );

    rol_lalign #(.XLEN(XLEN)) u_lalign (
        .op     (op_q),
        .lo     (lo_q),
        .rdata  (mem_rdata),
        .result (aligned)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_SW;
            load_q  <= 1'b0;
            size_q  <= SZ_BYTE;
            addr_q  <= '0;
            wdata_q <= '0;
            lo_q    <= 2'b00;
            rd_q    <= '0;
        end else if (state_q == ST_IDLE && start && dec_hit) begin
            op_q    <= dec_op;
            load_q  <= dec_load;
            size_q  <= dec_size;
            addr_q  <= gen_addr;
            wdata_q <= dec_load ? '0 : gen_wdata;
            lo_q    <= gen_lo;
            rd_q    <= rf_dat_idx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        done      = 1'b0;
        unhandled = 1'b0;
        rf_we     = 1'b0;
        mem_req   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = dec_hit ? ST_ACCESS : ST_REJECT;
                end
            end
            ST_ACCESS: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    done    = 1'b1;
                    rf_we   = load_q;
                    state_d = ST_IDLE;
                end
            end
            ST_REJECT: begin
                unhandled = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mem_we    = ~load_q;
    assign mem_size  = size_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rf_waddr  = rd_q;
    assign rf_wdata  = aligned;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_size) && $stable(mem_we)));

    // R10
    issue_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && instr[15:12] == 4'b0101) |=> mem_req);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !mem_req));

    // R11
    we_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done);

    // R11
    store_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !rf_we);

    // R1
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |-> (!mem_req && !done && !rf_we));

    // R1
    reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |=> !unhandled);

    // R3
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'd1) |-> !mem_addr[0]);

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00));

endmodule

// File: tb/rol_ldst_unit_test.sv
module rol_ldst_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        done, unhandled, rf_we, mem_req, mem_we;
    logic [2:0]  rf_base_idx, rf_off_idx, rf_dat_idx, rf_waddr;
    logic [31:0] rf_base_val, rf_off_val, rf_dat_val, rf_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] regs [8];
    int tests = 0, fails = 0;
    int lat = 0, wcnt = 0;
    int n_req, n_done, n_we, n_unh;
    logic [31:0] c_addr, c_wdata, c_rfw;
    logic [1:0]  c_size;
    logic        c_we;
    logic [2:0]  c_waddr;

    always #4 clk = ~clk;

    assign rf_base_val = regs[rf_base_idx];
    assign rf_off_val  = regs[rf_off_idx];
    assign rf_dat_val  = regs[rf_dat_idx];

    rol_ldst_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .done(done), .unhandled(unhandled),
        .rf_base_idx(rf_base_idx), .rf_off_idx(rf_off_idx), .rf_dat_idx(rf_dat_idx),
        .rf_base_val(rf_base_val), .rf_off_val(rf_off_val), .rf_dat_val(rf_dat_val),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mb(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [31:0] bus_data(input logic [31:0] a, input logic [1:0] sz);
        if (sz == 2'd2) return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
        if (sz == 2'd1) return {16'hA5C3, mb(a + 1), mb(a)};
        return {24'h7E3C91, mb(a)};
    endfunction

    // memory model: responds after lat idle cycles of a held request
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt == lat) begin
                mem_ready = 1'b1;
                mem_rdata = bus_data(mem_addr, mem_size);
                wcnt = 0;
            end else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    always @(negedge clk) begin
        #1;
        if (mem_req && mem_ready) begin
            n_req++;
            c_addr = mem_addr; c_size = mem_size; c_we = mem_we; c_wdata = mem_wdata;
        end
        if (done) n_done++;
        if (unhandled) n_unh++;
        if (rf_we) begin
            n_we++; c_waddr = rf_waddr; c_rfw = rf_wdata;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] w);
        n_req = 0; n_done = 0; n_we = 0; n_unh = 0;
        @(negedge clk);
        instr = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0; instr = 16'h0000;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_load(input logic [2:0] op, input logic [31:0] e);
        logic [31:0] r, a2, a4;
        a4 = e & 32'hFFFF_FFFC;
        a2 = e & 32'hFFFF_FFFE;
        r = '0;
        case (op)
            3'b010: for (int i = 0; i < 4; i++) r[8*i +: 8] = mb(a4 + ((i + e[1:0]) & 3));
            3'b011: r = {24'h0, mb(e)};
            3'b101: r = e[0] ? {mb(a2), 16'h0, mb(a2 + 1)} : {16'h0, mb(a2 + 1), mb(a2)};
            3'b110: r = {{24{mb(e)[7]}}, mb(e)};
            3'b111: r = {{16{mb(a2 + 1)[7]}}, mb(a2 + 1), mb(a2)};
            default: r = '0;
        endcase
        return r;
    endfunction

    // op = {bit9, bits[11:10]}
    task automatic run(input logic [2:0] op, input logic [31:0] bv, input logic [31:0] ov,
                       input logic [31:0] dv, input int rb, input int ro, input int rd);
        logic [31:0] e, ea;
        logic [1:0]  sz;
        logic        ld;
        logic [31:0] wd;
        regs[rb] = bv; regs[ro] = ov; regs[rd] = dv;
        e  = bv + ov;
        ld = !(op == 3'b000 || op == 3'b001 || op == 3'b100);
        sz = (op == 3'b000 || op == 3'b010) ? 2'd2 :
             (op == 3'b001 || op == 3'b011 || op == 3'b110) ? 2'd0 : 2'd1;
        ea = (sz == 2'd2) ? (e & 32'hFFFF_FFFC) : (sz == 2'd1) ? (e & 32'hFFFF_FFFE) : e;
        wd = (sz == 2'd2) ? dv : (sz == 2'd1) ? {16'h0, dv[15:0]} : {24'h0, dv[7:0]};
        issue({4'b0101, op[1:0], op[2], 3'(ro), 3'(rb), 3'(rd)});
        chk(n_req == 1 && n_done == 1, "R10 one request one done", 32'(n_req), 32'd1);
        chk(c_addr == ea, "R2/R3 bus address", c_addr, ea);
        chk(c_size == sz, "R3 size code", 32'(c_size), 32'(sz));
        chk(c_we == !ld, "R4/R5 direction", 32'(c_we), 32'(!ld));
        if (!ld) begin
            chk(c_wdata == wd, "R6 store data", c_wdata, wd);
            chk(n_we == 0, "R11 store without write-back", 32'(n_we), 32'd0);
        end else begin
            chk(n_we == 1 && c_waddr == 3'(rd), "R11 write-back pulse/index",
                {29'(n_we), c_waddr}, {29'd1, 3'(rd)});
            chk(c_rfw == exp_load(op, e),
                (op == 3'b010) ? "R7 word rotate" :
                (op == 3'b101) ? "R8 unsigned half" : "R9 extension",
                c_rfw, exp_load(op, e));
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk(!mem_req && !done && !rf_we && !unhandled, "reset outputs idle",
            {mem_req, done, rf_we, unhandled}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R7 R8 R9: every op, every low address, several values and latencies
        for (int p = 0; p < 3; p++) begin
            for (int op = 0; op < 8; op++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    int k;
                    k = p * 32 + op * 4 + lo;
                    lat = k % 3;
                    run(3'(op), 32'h2000_0040 + 32'(p) * 32'h0113_5370,
                        32'(lo) + 32'(p) * 32'h40 + 32'(op) * 32'h104,
                        32'hC0DE_F08D ^ (32'(k) * 32'h1111_2223),
                        (k + 3) % 8, (k + 5) % 8, k % 8);
                end
            end
        end

        // R2 wraparound of the address sum, with misaligned base bits
        lat = 1;
        run(3'b010, 32'hFFFF_FFFE, 32'h0000_0005, 32'h0, 1, 2, 3);
        run(3'b111, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0, 4, 5, 6);
        run(3'b000, 32'hFFFF_FF03, 32'h0000_0100, 32'h89AB_CDEF, 7, 0, 2);

        // R1 every other top nibble is refused
        for (int n = 0; n < 16; n++) begin
            if (n != 5) begin
                issue({4'(n), 12'hA5C});
                chk(n_unh == 1, "R1 refusal pulse", 32'(n_unh), 32'd1);
                chk(n_req == 0 && n_done == 0 && n_we == 0, "R1 no activity",
                    32'(n_req + n_done + n_we), 32'd0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule